// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard and forwarding control for a five-stage in-order pipeline with the stages fetch (IF), register read (RF), execute (ALU), memory (MEM) and writeback (WB). Each cycle it looks at the two source register numbers of the instruction in RF and at the destination, write-enable and load flags of the instructions in ALU, MEM and WB. From these it chooses where each RF operand comes from. It also decides whether RF and IF must hold while a bubble enters ALU, and whether the instruction just fetched behind a taken branch must be annulled.

All outputs are combinational functions of the current stage contents. The pipeline registers, register file, datapath and decoder sit outside the block. A load that the consumer in RF depends on holds that consumer until the load reaches WB. From there the value is forwarded. A consumer directly behind a load therefore costs two bubbles. A branch resolved in RF kills the single instruction fetched after it, unless RF is stalled in that cycle.

Top module: `hz_ctrl`

## Requirements
- R1: Each operand select is 2 bits wide with codes 0 = register file, 1 = ALU result, 2 = MEM result and 3 = WB result. Code 0 is given when no stage qualifies. After reset, with all inputs zero, every output is 0.
- R2: A source equal to the destination of a writing instruction in ALU selects code 1.
- R3: A source that matches only a writing instruction in MEM selects code 2. A source that matches only a writing instruction in WB selects code 3.
- R4: When several writing stages match, the youngest wins: ALU over MEM over WB.
- R5: Source register 31 always selects code 0 and never causes a stall.
- R6: stall_o and bubble_o are 1 when the youngest matching writer of a source is a load in ALU or MEM. A load in WB is forwarded with code 3 and no stall. A consumer directly behind a load stalls for exactly 2 cycles.
- R7: The stall is the OR of the checks for both sources, so a hazard on the second source alone stalls.
- R8: annul_o follows br_taken_i except in a stalled cycle, when it is 0.
- R9: A stage with write-enable 0 is ignored for selection and for stalls, even with its load flag set.
- R10: A loop of load, multiply, XOR that uses the load result, and a taken branch on the multiply result repeats every 6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock (checks only) |
| rst_ni | input | 1 | Active-low asynchronous reset (checks only) |
| rs1_i | input | 5 | First source register of the RF instruction |
| rs2_i | input | 5 | Second source register of the RF instruction |
| alu_rd_i | input | 5 | Destination of the ALU instruction |
| alu_we_i | input | 1 | ALU instruction writes a register |
| alu_ld_i | input | 1 | ALU instruction is a load |
| mem_rd_i | input | 5 | Destination of the MEM instruction |
| mem_we_i | input | 1 | MEM instruction writes a register |
| mem_ld_i | input | 1 | MEM instruction is a load |
| wb_rd_i | input | 5 | Destination of the WB instruction |
| wb_we_i | input | 1 | WB instruction writes a register |
| br_taken_i | input | 1 | Branch in RF resolved taken |
| byp1_o | output | 2 | Operand select for the first source |
| byp2_o | output | 2 | Operand select for the second source |
| stall_o | output | 1 | Hold IF and RF |
| bubble_o | output | 1 | Insert a NOP into ALU |
| annul_o | output | 1 | Replace the IF instruction with a NOP |

## Verification
Every output depends only on the present stage contents. Each result is therefore due in the same cycle as the stimulus, with no register between them. The bench applies each stage pattern one time unit after the rising edge and samples mid-cycle, long before the next edge. A behavioural pipeline model in the bench advances its stages on the expected stall and annul values. It checks the two-cycle load stall and the six-cycle loop cadence by counting cycles between repeated entries of the load into RF.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    BYP_RF  = 2'd0,
    BYP_ALU = 2'd1,
    BYP_MEM = 2'd2,
    BYP_WB  = 2'd3
  } byp_sel_e;

  localparam int unsigned N_LATE = 3;  // producer stages: ALU, MEM, WB
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [REG_W-1:0]                  src_i,
  input  logic [N_LATE-1:0][REG_W-1:0]      rd_i,   // 0 = ALU, 1 = MEM, 2 = WB
  input  logic [N_LATE-1:0]                 we_i,
  input  logic [N_LATE-2:0]                 ld_i,   // WB load needs no hold
  output byp_sel_e                          sel_o,
  output logic                              ld_hz_o
);
  localparam logic [REG_W-1:0] ZERO_IDX = REG_W'(ZERO_REG);

  logic [N_LATE-1:0] hit;

  for (genvar k = 0; k < N_LATE; k++) begin : g_hit
    assign hit[k] = we_i[k] && (rd_i[k] == src_i) && (src_i != ZERO_IDX);
  end

  // youngest producer wins
  always_comb begin
    sel_o   = BYP_RF;
    ld_hz_o = 1'b0;
    if (hit[0]) begin
      sel_o   = BYP_ALU;
      ld_hz_o = ld_i[0];
    end else if (hit[1]) begin
      sel_o   = BYP_MEM;
      ld_hz_o = ld_i[1];
    end else if (hit[2]) begin
      sel_o   = BYP_WB;
    end
  end

  AST_ZERO_SRC_FROM_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == ZERO_IDX) |-> (sel_o == BYP_RF && !ld_hz_o)); // R5
  AST_ALU_SEL_HAS_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == BYP_ALU) |-> (we_i[0] && rd_i[0] == src_i)); // R2
  AST_MEM_SEL_ALU_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == BYP_MEM) |-> !(we_i[0] && rd_i[0] == src_i)); // R4
  AST_HAZARD_NOT_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hz_o |-> (sel_o == BYP_ALU || sel_o == BYP_MEM)); // R6
endmodule

// File: rtl/hz_flow_ctl.sv
module hz_flow_ctl #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] ld_hz_i,
  input  logic             br_taken_i,
  output logic             stall_o,
  output logic             bubble_o,
  output logic             annul_o
);
  assign stall_o  = |ld_hz_i;
  assign bubble_o = stall_o;
  // branch operands are not valid while stalled
  assign annul_o  = br_taken_i && !stall_o;

  AST_STALL_OVER_ANNUL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_o && annul_o)); // R8
  AST_ANNUL_FROM_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> br_taken_i); // R8
  AST_STALL_FROM_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hz_i != '0) |-> (stall_o && bubble_o)); // R7
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic [REG_W-1:0] alu_rd_i,
  input  logic             alu_we_i,
  input  logic             alu_ld_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic             mem_ld_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  input  logic             br_taken_i,
  output logic [1:0]       byp1_o,
  output logic [1:0]       byp2_o,
  output logic             stall_o,
  output logic             bubble_o,
  output logic             annul_o
);
  localparam int unsigned N_SRC = 2;

  logic [N_LATE-1:0][REG_W-1:0] rd_v;
  logic [N_LATE-1:0]            we_v;
  logic [N_LATE-2:0]            ld_v;
  logic [N_SRC-1:0][REG_W-1:0]  src_v;
  byp_sel_e                     sel_v [N_SRC];
  logic [N_SRC-1:0]             hz_v;

  assign rd_v  = {wb_rd_i, mem_rd_i, alu_rd_i};
  assign we_v  = {wb_we_i, mem_we_i, alu_we_i};
  assign ld_v  = {mem_ld_i, alu_ld_i};
  assign src_v = {rs2_i, rs1_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    hz_src_match #(
      .REG_W   (REG_W),
      .ZERO_REG(ZERO_REG)
    ) u_match (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_v[g]),
      .rd_i   (rd_v),
      .we_i   (we_v),
      .ld_i   (ld_v),
      .sel_o  (sel_v[g]),
      .ld_hz_o(hz_v[g])
    );
  end

  assign byp1_o = sel_v[0];
  assign byp2_o = sel_v[1];

  hz_flow_ctl #(
    .N_SRC(N_SRC)
  ) u_flow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_hz_i   (hz_v),
    .br_taken_i(br_taken_i),
    .stall_o   (stall_o),
    .bubble_o  (bubble_o),
    .annul_o   (annul_o)
  );

  AST_STALL_HAS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ((alu_we_i && alu_ld_i) || (mem_we_i && mem_ld_i))); // R6
  AST_IDLE_ALU_NOT_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_we_i |-> (byp1_o != BYP_ALU && byp2_o != BYP_ALU)); // R9
  AST_WB_SEL_HAS_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp1_o == BYP_WB) |-> (wb_we_i && wb_rd_i == rs1_i)); // R3
endmodule

// File: tb/test_hz_ctrl.sv
module test_hz_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int rd; bit we; bit ld; int s1; int s2; bit br;
  } ins_t;

  logic clk = 0, rst_n = 0;
  logic [4:0] rs1, rs2, alu_rd, mem_rd, wb_rd;
  logic alu_we, alu_ld, mem_we, mem_ld, wb_we, br_taken;
  logic [1:0] byp1, byp2;
  logic stall, bubble, annul;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_ctrl i_hz_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rs1_i(rs1), .rs2_i(rs2),
    .alu_rd_i(alu_rd), .alu_we_i(alu_we), .alu_ld_i(alu_ld),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_ld_i(mem_ld),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we), .br_taken_i(br_taken),
    .byp1_o(byp1), .byp2_o(byp2), .stall_o(stall), .bubble_o(bubble), .annul_o(annul)
  );

  function automatic ins_t nop();
    ins_t n = '{rd: 31, we: 0, ld: 0, s1: 31, s2: 31, br: 0};
    return n;
  endfunction

  function automatic ins_t mk(int rd, bit we, bit ld, int s1, int s2, bit br);
    ins_t n = '{rd: rd, we: we, ld: ld, s1: s1, s2: s2, br: br};
    return n;
  endfunction

  task automatic cmp(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // reference: scan producers youngest first
  function automatic void ref_src(int s, ins_t a, ins_t m, ins_t w, output int sel, output bit hz);
    ins_t st[3];
    st[0] = a; st[1] = m; st[2] = w;
    sel = 0; hz = 0;
    if (s == 31) return;
    for (int k = 0; k < 3; k++)
      if (st[k].we && st[k].rd == s) begin
        sel = k + 1;
        hz  = (k < 2) && st[k].ld;
        return;
      end
  endfunction

  function automatic string sel_tag(int s, ins_t a, ins_t m, ins_t w, int e);
    int n = 0;
    if (s == 31) return "R5";
    if (a.we && a.rd == s) n++;
    if (m.we && m.rd == s) n++;
    if (w.we && w.rd == s) n++;
    if (n > 1) return "R4";
    case (e)
      0: return "R1";
      1: return "R2";
      default: return "R3";
    endcase
  endfunction

  // apply one cycle of stage contents, compare all outputs mid-cycle
  task automatic cycle(string tag, ins_t r, ins_t a, ins_t m, ins_t w, bit br,
                       output bit est, output bit ean);
    int e1, e2; bit h1, h2;
    @(posedge clk); #1;
    rs1 = 5'(r.s1); rs2 = 5'(r.s2);
    alu_rd = 5'(a.rd); alu_we = a.we; alu_ld = a.ld;
    mem_rd = 5'(m.rd); mem_we = m.we; mem_ld = m.ld;
    wb_rd = 5'(w.rd); wb_we = w.we; br_taken = br;
    #(CLK_PERIOD/2 - 2);
    ref_src(r.s1, a, m, w, e1, h1);
    ref_src(r.s2, a, m, w, e2, h2);
    est = h1 || h2;
    ean = br && !est;
    cmp(tag != "" ? tag : sel_tag(r.s1, a, m, w, e1), int'(byp1), e1);
    cmp(tag != "" ? tag : sel_tag(r.s2, a, m, w, e2), int'(byp2), e2);
    cmp(tag != "" ? tag : (h2 && !h1 ? "R7" : "R6"), int'(stall), int'(est));
    cmp(tag != "" ? tag : "R6", int'(bubble), int'(est));
    cmp(tag != "" ? tag : "R8", int'(annul), int'(ean));
  endtask

  // behavioural pipeline running a program
  ins_t prog[$];
  int   lb_iters;
  int   ld_entry[$];
  int   stall_total;

  function automatic ins_t fetch(int pc);
    if (pc < prog.size()) return prog[pc];
    return nop();
  endfunction

  task automatic run_prog(int ncyc, int max_taken);
    ins_t r, a, m, w;
    int pc, taken_cnt, cyc;
    bit est, ean, tk;
    r = nop(); a = nop(); m = nop(); w = nop();
    pc = 0; taken_cnt = 0; cyc = 0; stall_total = 0;
    ld_entry.delete();
    for (int c = 0; c < ncyc; c++) begin
      tk = r.br && (taken_cnt < max_taken);
      cycle("", r, a, m, w, tk, est, ean);
      cyc++;
      w = m; m = a;
      if (est) begin
        a = nop();
        stall_total++;
      end else begin
        a = r;
        if (ean) r = nop();
        else begin
          r = fetch(pc);
          if (pc == 0) ld_entry.push_back(cyc);
        end
        if (tk) begin pc = 0; taken_cnt++; end
        else pc++;
      end
    end
    lb_iters = taken_cnt;
  endtask

  initial begin
    bit est, ean;
    rs1 = 0; rs2 = 0; alu_rd = 0; alu_we = 0; alu_ld = 0;
    mem_rd = 0; mem_we = 0; mem_ld = 0; wb_rd = 0; wb_we = 0; br_taken = 0;
    #(CLK_PERIOD*2 + 3);
    // R1: reset state, all inputs zero
    cmp("R1", int'(byp1), 0); cmp("R1", int'(byp2), 0);
    cmp("R1", int'(stall), 0); cmp("R1", int'(bubble), 0); cmp("R1", int'(annul), 0);
    @(negedge clk); rst_n = 1;

    // directed
    cycle("R2", mk(0,0,0,4,31,0), mk(4,1,0,1,1,0), nop(), nop(), 0, est, ean);
    cycle("R3", mk(0,0,0,6,7,0), nop(), mk(6,1,0,1,1,0), mk(7,1,0,1,1,0), 0, est, ean);
    cycle("R4", mk(0,0,0,9,9,0), mk(9,1,0,0,0,0), mk(9,1,1,0,0,0), mk(9,1,0,0,0,0), 0, est, ean);
    cycle("R4", mk(0,0,0,9,2,0), nop(), mk(9,1,0,0,0,0), mk(9,1,0,0,0,0), 0, est, ean);
    cycle("R5", mk(0,0,0,31,31,1), mk(31,1,1,0,0,0), mk(31,1,1,0,0,0), mk(31,1,0,0,0,0), 1, est, ean);
    cycle("R6", mk(0,0,0,3,0,0), mk(3,1,1,0,0,0), nop(), nop(), 0, est, ean);
    cycle("R6", mk(0,0,0,3,0,0), mk(3,1,0,0,0,0), mk(3,1,1,0,0,0), nop(), 0, est, ean);
    cycle("R6", mk(0,0,0,3,0,0), nop(), nop(), mk(3,1,1,0,0,0), 0, est, ean);
    cycle("R7", mk(0,0,0,1,5,0), nop(), mk(5,1,1,0,0,0), nop(), 0, est, ean);
    cycle("R8", mk(0,0,0,5,0,1), nop(), mk(5,1,1,0,0,0), nop(), 1, est, ean);
    cycle("R8", mk(0,0,0,5,0,1), nop(), mk(5,1,0,0,0,0), nop(), 1, est, ean);
    cycle("R9", mk(0,0,0,8,8,0), mk(8,0,1,0,0,0), mk(8,1,0,0,0,0), nop(), 0, est, ean);
    cycle("R9", mk(0,0,0,8,2,0), mk(8,0,1,0,0,0), mk(8,0,1,0,0,0), mk(8,0,0,0,0,0), 0, est, ean);

    // R6: consumer right behind a load holds for exactly two cycles
    prog.delete();
    prog.push_back(mk(5,1,1,0,31,0));
    prog.push_back(mk(6,1,0,5,31,0));
    run_prog(10, 0);
    cmp("R6", stall_total, 2);

    // R10: load / multiply / xor / branch loop
    prog.delete();
    prog.push_back(mk(1,1,1,0,31,0));   // load r1
    prog.push_back(mk(4,1,0,2,3,0));    // mul r4
    prog.push_back(mk(0,1,0,1,0,0));    // xor r0 <- r1
    prog.push_back(mk(0,1,0,4,31,1));   // branch on r4
    prog.push_back(mk(6,1,0,1,2,0));    // slot
    run_prog(40, 4);
    cmp("R10", lb_iters, 4);
    cmp("R10", ld_entry.size(), 5);
    for (int i = 1; i < ld_entry.size(); i++)
      cmp("R10", ld_entry[i] - ld_entry[i-1], 6);

    // random stage patterns over a small register set
    for (int i = 0; i < 3000; i++) begin
      int pool[5] = '{0, 1, 2, 3, 31};
      ins_t st[4];
      for (int k = 0; k < 4; k++)
        st[k] = mk(pool[$urandom_range(4)], 1'($urandom), 1'($urandom),
                   pool[$urandom_range(4)], pool[$urandom_range(4)], 1'($urandom));
      cycle("", st[0], st[1], st[2], st[3], st[0].br, est, ean);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule